// File: doc/BRIEF.md
# DRAM Power-Down Clock-Enable Sequencer

This block sits in a memory controller next to the command scheduler. It decides when the clock-enable output may drop so that the memory enters power-down, and it sequences the way back out. Read and write issues are tracked for their full duration. A read is busy for half its burst length in beats, plus the read postamble. A write is busy for half its burst length, plus the write postamble, plus a further half burst length. Clock-enable is never lowered while any of that time remains.

An enter request that arrives while a burst is still running is held. It is taken on the first cycle the tracker reports idle. On entry the block records whether any bank had an open row, which makes the mode active rather than precharge power-down. It keeps clock-enable low for a minimum number of cycles, and during that time only NOP or deselect is presented. Once that minimum has passed, an exit request raises clock-enable. The block then holds off the scheduler for a fixed exit delay and only afterwards raises command-ready again.

Top module: `pd_cke_seq`

## Requirements
- R1: After reset, `cke`=1, `cmd_ready`=1, `nop_cmd`=0 and `pd_active`=0.
- R2: A read issued in cycle t with burst length BL keeps the block busy for L = BL/2 + RD_POST cycles. With an enter request pending, `cke` is observed low for the first time L+1 cycles after the issue cycle.
- R3: A write issued in cycle t keeps the block busy for L = BL/2 + WR_POST + BL/2 cycles. With an enter request pending, `cke` is observed low for the first time L+1 cycles after the issue cycle. When issues overlap, the longer remaining time wins.
- R4: An enter request made while idle lowers `cke` at the next clock edge. An enter request made during a burst is held, and `cke` falls one edge after the burst ends.
- R5: `pd_active` takes the value of `bank_open` at the entry edge. It holds that value while `cke` is low and is 0 at all other times.
- R6: Once `cke` falls it stays low for at least MIN_NOP cycles. While it is low, `nop_cmd`=1 and `cmd_ready`=0. An exit request made before MIN_NOP has elapsed is held and honoured once it has.
- R7: On exit, `cke` rises one edge after the exit decision. `cmd_ready` stays 0 and `nop_cmd` stays 1 for exactly EXIT_DLY cycles with `cke` high, and then returns to 1 and 0 respectively.
- R8: Read or write issues and enter requests made while `cmd_ready` is 0 are ignored, and so are exit requests made while `cke` is high. None of them delays, repeats or shortens a later power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_issue | input | 1 | A read command is issued this cycle |
| wr_issue | input | 1 | A write command is issued this cycle |
| burst_len | input | BL_W | Burst length in beats, sampled together with an issue |
| bank_open | input | 1 | Some bank holds an open row |
| pd_enter_req | input | 1 | Request to enter power-down |
| pd_exit_req | input | 1 | Request to leave power-down |
| cke | output | 1 | Clock-enable to the memory |
| nop_cmd | output | 1 | Scheduler must drive NOP or deselect |
| cmd_ready | output | 1 | A valid command may be issued |
| pd_active | output | 1 | 1 means active power-down, 0 means precharge power-down |

## Verification
On every cycle the assertions check several properties. An unfinished burst never lets clock-enable fall, and clock-enable falls only from the ready state. The minimum low time and the exit delay are never cut short. Whenever command-ready is high, clock-enable is high and no NOP is forced, and the active-power-down flag is seen only while clock-enable is low. Other behaviour can only be shown by the bench scenarios, each compared every cycle against a behavioural model: the exact cycle of entry after reads, writes and overlapping issues, the holding of early enter and exit requests, the captured row-open flag, and the ignoring of stimulus given during power-down and exit.

// File: rtl/pd_cke_pkg.sv
package pd_cke_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PD   = 2'd1,
        ST_EXIT = 2'd2
    } pd_state_e;

    typedef struct packed {
        pd_state_e state;
        logic      enter_pend;
        logic      exit_pend;
        logic      act;
    } pd_regs_t;

endpackage

// File: rtl/pd_delay_cnt.sv
module pd_delay_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R6/R7: a non-zero load always opens a waiting window
    p_load_blocks_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done);

endmodule

// File: rtl/pd_burst_guard.sv
module pd_burst_guard #(
    parameter int BL_W    = 4,
    parameter int RD_POST = 1,
    parameter int WR_POST = 1,
    parameter int CNT_W   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            rd_issue,
    input  logic            wr_issue,
    input  logic [BL_W-1:0] burst_len,
    output logic            idle
);

    logic [CNT_W-1:0] half_w, rd_load, wr_load, dec_v, new_v;
    logic [CNT_W-1:0] busy_d, busy_q;
    logic             rd_take, wr_take;

    always_comb begin
        rd_take = arm && rd_issue;
        wr_take = arm && wr_issue;
        half_w  = CNT_W'(burst_len >> 1);
        rd_load = half_w + CNT_W'(RD_POST);
        wr_load = half_w + half_w + CNT_W'(WR_POST);
        dec_v   = (busy_q != '0) ? busy_q - 1'b1 : '0;
        new_v   = '0;
        if (rd_take) new_v = rd_load;
        if (wr_take && wr_load > new_v) new_v = wr_load;
        busy_d  = (new_v > dec_v) ? new_v : dec_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    assign idle = (busy_q == '0) && !rd_take && !wr_take;

    // R2: an accepted read always leaves busy time behind it
    p_read_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && rd_issue && RD_POST > 0) |=> busy_q != '0);
    // R3: an accepted write always leaves busy time behind it
    p_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && wr_issue && WR_POST > 0) |=> busy_q != '0);

endmodule

// File: rtl/pd_cke_seq.sv
module pd_cke_seq
    import pd_cke_pkg::*;
#(
    parameter int BL_W     = 4,
    parameter int RD_POST  = 1,
    parameter int WR_POST  = 1,
    parameter int MIN_NOP  = 4,
    parameter int EXIT_DLY = 3,
    parameter int CNT_W    = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_issue,
    input  logic            wr_issue,
    input  logic [BL_W-1:0] burst_len,
    input  logic            bank_open,
    input  logic            pd_enter_req,
    input  logic            pd_exit_req,
    output logic            cke,
    output logic            nop_cmd,
    output logic            cmd_ready,
    output logic            pd_active
);

    localparam logic [CNT_W-1:0] NOP_LD  = CNT_W'(MIN_NOP - 1);
    localparam logic [CNT_W-1:0] EXIT_LD = CNT_W'(EXIT_DLY - 1);

    pd_regs_t regs_d, regs_q;
    logic     burst_idle, nop_done, exit_done;
    logic     nop_load, exit_load;

    pd_burst_guard #(
        .BL_W(BL_W), .RD_POST(RD_POST), .WR_POST(WR_POST), .CNT_W(CNT_W)
    ) u_guard (
        .clk(clk), .rst_n(rst_n),
        .arm(regs_q.state == ST_RUN),
        .rd_issue(rd_issue), .wr_issue(wr_issue), .burst_len(burst_len),
        .idle(burst_idle)
    );

    pd_delay_cnt #(.CNT_W(CNT_W)) u_nop_cnt (
        .clk(clk), .rst_n(rst_n), .load(nop_load), .load_val(NOP_LD),
        .done(nop_done)
    );

    pd_delay_cnt #(.CNT_W(CNT_W)) u_exit_cnt (
        .clk(clk), .rst_n(rst_n), .load(exit_load), .load_val(EXIT_LD),
        .done(exit_done)
    );

    always_comb begin
        regs_d    = regs_q;
        nop_load  = 1'b0;
        exit_load = 1'b0;
        unique case (regs_q.state)
            ST_RUN: begin
                if ((regs_q.enter_pend || pd_enter_req) && burst_idle) begin
                    regs_d.state      = ST_PD;
                    regs_d.enter_pend = 1'b0;
                    regs_d.act        = bank_open;
                    nop_load          = 1'b1;
                end else if (pd_enter_req) begin
                    regs_d.enter_pend = 1'b1;
                end
            end
            ST_PD: begin
                if (nop_done && (regs_q.exit_pend || pd_exit_req)) begin
                    regs_d.state     = ST_EXIT;
                    regs_d.exit_pend = 1'b0;
                    regs_d.act       = 1'b0;
                    exit_load        = 1'b1;
                end else if (pd_exit_req) begin
                    regs_d.exit_pend = 1'b1;
                end
            end
            ST_EXIT: begin
                if (exit_done) regs_d.state = ST_RUN;
            end
            default: regs_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state      <= ST_RUN;
            regs_q.enter_pend <= 1'b0;
            regs_q.exit_pend  <= 1'b0;
            regs_q.act        <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cke       = (regs_q.state != ST_PD);
    assign nop_cmd   = (regs_q.state != ST_RUN);
    assign cmd_ready = (regs_q.state == ST_RUN);
    assign pd_active = regs_q.act;

    // R4: an unfinished burst never lets clock-enable fall
    p_burst_holds_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_RUN && !burst_idle) |=> cke);
    // R4: power-down is only entered from the ready state
    p_enter_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cmd_ready) |=> cke);
    // R6: minimum low time is never cut short
    p_min_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_PD && !nop_done) |=> !cke);
    // R7: exit delay is never cut short
    p_exit_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_EXIT && !exit_done) |=> !cmd_ready);
    // R7: readiness implies a running, unrestricted command bus
    p_ready_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (cke && !nop_cmd));
    // R5: status flag only seen during power-down
    p_status_in_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> !cke);

endmodule

// File: tb/sim_pd_cke_seq.sv
module sim_pd_cke_seq;

    localparam int CLK_PERIOD = 10;
    localparam int BL_W = 4, RD_POST = 1, WR_POST = 1;
    localparam int MIN_NOP = 4, EXIT_DLY = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_issue = 0, wr_issue = 0, bank_open = 0, pd_enter_req = 0, pd_exit_req = 0;
    logic [BL_W-1:0] burst_len = 4'd8;
    logic cke, nop_cmd, cmd_ready, pd_active;

    int checks = 0, errors = 0;
    int m_st = 0, m_busy = 0, m_pend = 0, m_nop = 0, m_ex = 0, m_xp = 0, m_act = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pd_cke_seq #(.BL_W(BL_W), .RD_POST(RD_POST), .WR_POST(WR_POST),
                 .MIN_NOP(MIN_NOP), .EXIT_DLY(EXIT_DLY), .CNT_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .wr_issue(wr_issue),
        .burst_len(burst_len), .bank_open(bank_open), .pd_enter_req(pd_enter_req),
        .pd_exit_req(pd_exit_req), .cke(cke), .nop_cmd(nop_cmd),
        .cmd_ready(cmd_ready), .pd_active(pd_active)
    );

    // behavioural reference: 0 ready, 1 powered down, 2 exiting
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_busy = 0; m_pend = 0; m_nop = 0; m_ex = 0; m_xp = 0; m_act = 0;
        end else begin
            case (m_st)
                0: begin
                    int ld, nb;
                    ld = 0;
                    if (rd_issue) ld = burst_len / 2 + RD_POST;
                    if (wr_issue && burst_len + WR_POST > ld) ld = burst_len + WR_POST;
                    nb = (m_busy > 0) ? m_busy - 1 : 0;
                    if (ld > nb) nb = ld;
                    if ((m_pend || pd_enter_req) && m_busy == 0 && !rd_issue && !wr_issue) begin
                        m_st = 1; m_nop = MIN_NOP - 1; m_act = bank_open; m_pend = 0;
                    end else if (pd_enter_req) m_pend = 1;
                    m_busy = nb;
                end
                1: begin
                    if (m_nop == 0 && (m_xp || pd_exit_req)) begin
                        m_st = 2; m_ex = EXIT_DLY - 1; m_xp = 0; m_act = 0;
                    end else begin
                        if (m_nop > 0) m_nop--;
                        if (pd_exit_req) m_xp = 1;
                    end
                end
                default: begin
                    if (m_ex == 0) m_st = 0; else m_ex--;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk("R4 cke", cke, m_st != 1);
        chk("R6 nop_cmd", nop_cmd, m_st != 0);
        chk("R7 cmd_ready", cmd_ready, m_st == 0);
        chk("R5 pd_active", pd_active, (m_st == 1) ? logic'(m_act) : 1'b0);
    endtask

    // drive one cycle of stimulus, then compare after the edge
    task automatic step(input logic rd, input logic wr, input logic en, input logic ex);
        rd_issue = rd; wr_issue = wr; pd_enter_req = en; pd_exit_req = ex;
        @(negedge clk);
        compare_model();
        rd_issue = 0; wr_issue = 0; pd_enter_req = 0; pd_exit_req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic leave_pd();
        for (int i = 0; i < 30 && !cke; i++) step(0, 0, 0, 1);
        for (int i = 0; i < 30 && !cmd_ready; i++) step(0, 0, 0, 0);
    endtask

    task automatic count_entry(input string tag, input int exp_n);
        int n;
        n = 0;
        while (cke && n < 40) begin
            step(0, 0, 0, 0);
            n++;
        end
        checks++;
        if (n != exp_n) begin
            errors++;
            $display("FAIL %s entry delay actual=%0d expected=%0d", tag, n, exp_n);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cke", cke, 1'b1);
        chk("R1 cmd_ready", cmd_ready, 1'b1);
        chk("R1 nop_cmd", nop_cmd, 1'b0);
        chk("R1 pd_active", pd_active, 1'b0);

        // R4 idle entry, R5 active mode, R6 early exit held
        bank_open = 1;
        step(0, 0, 1, 0);
        chk("R4 immediate entry", cke, 1'b0);
        chk("R5 active captured", pd_active, 1'b1);
        bank_open = 0;
        step(0, 0, 0, 1);
        idle(6);
        chk("R7 ready back", cmd_ready, 1'b1);

        // R2 read, BL=8: L=5
        burst_len = 4'd8;
        step(1, 0, 1, 0);
        count_entry("R2", 6);
        chk("R5 precharge mode", pd_active, 1'b0);
        leave_pd();

        // R3 write, BL=8: L=9
        step(0, 1, 1, 0);
        count_entry("R3", 10);
        leave_pd();

        // R3 overlap: write then a short read
        burst_len = 4'd4;
        step(0, 1, 0, 0);
        step(1, 0, 1, 0);
        idle(12);
        leave_pd();

        // R8: issues and requests during power-down and exit are ignored
        step(0, 0, 1, 0);
        step(1, 1, 1, 0);
        idle(4);
        step(0, 0, 1, 1);
        step(1, 0, 1, 0);
        for (int i = 0; i < 10 && !cmd_ready; i++) step(0, 0, 0, 0);
        idle(3);
        chk("R8 no re-entry", cke, 1'b1);

        // R8: exit request while running is not remembered
        step(0, 0, 0, 1);
        step(0, 0, 1, 0);
        idle(8);
        chk("R8 stays down", cke, 1'b0);
        leave_pd();

        // R2 short read BL=4 with pending enter
        burst_len = 4'd4;
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        idle(6);
        leave_pd();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule